// File: doc/BRIEF.md
# USART Baud and Serial Clock Generator

This block derives the bit-timing enables for a serial transmitter and receiver from the system clock. A programmable down-counter divides the system clock by the divisor plus one. Each time it reaches zero it produces a one-cycle base tick. The receiver takes that base tick directly as its sampling rate. A second stage divides the base tick again for the transmitter, and the ratio of that stage depends on the selected mode.

Three control inputs pick the mode: a synchronous select, a double-speed select and a clock-direction select. In asynchronous mode the transmitter runs at one sixteenth or one eighth of the base rate. In synchronous mode with internal clocking, the block drives a serial clock out at half the base rate. In synchronous mode with external clocking, a serial clock from outside is synchronized to the system clock and edge-detected, and its edges take the place of the internal divider. A polarity input chooses which serial-clock edge launches transmit data and which one samples receive data.

The divisor is loaded with two byte writes, the upper bits first. Writing the lower byte reloads the counter at once with the full value.

Top module: `baud_clock_gen`

## Requirements
- R1: With clocking internal (asynchronous mode, or synchronous mode with clkPinOut=1) and divisor D, rxBaseTick is high for one cycle out of every D+1 system cycles.
- R2: A divLoWe write of low byte L, with stored upper bits H, loads the counter with D={H,L} on that clock edge, even when the counter is part-way through a count or at zero. The first rxBaseTick is visible D cycles after that edge, where D=0 means the cycle right after the edge.
- R3: divHiWe stores divData[3:0] as divisor bits 11:8. On its own it neither reloads the counter nor starts ticking, so a divisor of 0x102 gives a base period of 259 cycles.
- R4: In asynchronous mode (syncMode=0, dblSpeed=0), txTick fires on every 16th rxBaseTick, coinciding with it.
- R5: In asynchronous mode with dblSpeed=1, txTick fires on every 8th rxBaseTick, coinciding with it.
- R6: In synchronous master mode (syncMode=1, clkPinOut=1), clkOut starts low after reset and toggles on the cycle after each rxBaseTick. txTick fires on every 2nd rxBaseTick. dblSpeed has no effect in this mode.
- R7: In synchronous master mode, txTick occurs while clkOut equals clkPolarity, so the next clkOut edge is rising when clkPolarity=0 and falling when clkPolarity=1.
- R8: In synchronous slave mode (syncMode=1, clkPinOut=0), extClk passes through two synchronizer flops and an edge detector. Each edge produces a single-cycle pulse, visible in the cycle after the second system clock edge that samples the new level. With clkPolarity=0, rising edges drive txTick and falling edges drive rxBaseTick. clkPolarity=1 swaps the two. The internal counter produces no ticks in this mode, and clkOut stays low in every mode other than synchronous master.
- R9: A synchronous active-high rst clears the counter, the divisor, the prescaler, the clock toggle and the synchronizer. No tick of any kind then appears until the first divLoWe write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| divHiWe | input | 1 | Write strobe for divisor bits 11:8 |
| divLoWe | input | 1 | Write strobe for divisor bits 7:0; reloads the counter |
| divData | input | 8 | Write data for either divisor byte |
| syncMode | input | 1 | 1 = synchronous mode |
| dblSpeed | input | 1 | 1 = double-speed asynchronous mode |
| clkPinOut | input | 1 | 1 = internal (master) clocking, 0 = external (slave) clocking |
| clkPolarity | input | 1 | Serial clock edge selection in synchronous mode |
| extClk | input | 1 | External serial clock, slower than one quarter of clk |
| txTick | output | 1 | Single-cycle transmitter bit enable |
| rxBaseTick | output | 1 | Single-cycle receiver base enable |
| clkOut | output | 1 | Serial clock level driven in synchronous master mode |

## Verification
The bench builds the block with its defaults: a 12-bit divisor split into an 8-bit lower byte, a 4-bit prescaler for ratios of 16 and 8, and a two-flop synchronizer. These values keep every divisor from 0 to the full-scale value of 4095 within reach. The bench can therefore check the single-cycle base period at D=0, the period of 4096 cycles at the top of the range, and a divisor that uses the upper byte. The two-flop chain fixes the external-edge latency at a known cycle, and the bench checks the slave ticks against that cycle for both polarities.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC_NORM  = 2'd0,
    MODE_ASYNC_DBL   = 2'd1,
    MODE_SYNC_MASTER = 2'd2,
    MODE_SYNC_SLAVE  = 2'd3
  } bcg_mode_e;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic loadHi;
    logic loadLo;
    logic reloadCnt;
    logic decCnt;
    logic prescStep;
    logic prescClear;
    logic toggleStep;
  } bcg_strobes_t;

endpackage

// File: rtl/bcg_datapath.sv
module bcg_datapath
  import bcg_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int BYTE_W      = 8,
  parameter int PRESC_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  bcg_strobes_t       strb,
  input  logic [BYTE_W-1:0]  wrData,
  input  logic               extClk,
  output logic               cntZero,
  output logic               armed,
  output logic [PRESC_W-1:0] prescCnt,
  output logic               toggleQ,
  output logic               extRise,
  output logic               extFall
);

  localparam int HI_W = DIV_W - BYTE_W;

  logic [HI_W-1:0]  divHi;
  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] loValue;

  assign loValue = {divHi, wrData};

  // Upper divisor bits: held until the lower byte completes the value
  always_ff @(posedge clk) begin
    if (rst)              divHi <= '0;
    else if (strb.loadHi) divHi <= wrData[HI_W-1:0];
  end

  // Full divisor and arming flag
  always_ff @(posedge clk) begin
    if (rst) begin
      divReg <= '0;
      armed  <= 1'b0;
    end else if (strb.loadLo) begin
      divReg <= loValue;
      armed  <= 1'b1;
    end
  end

  // Down-counter: lower-byte write takes priority over the zero reload
  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (strb.loadLo)    cnt <= loValue;
    else if (strb.reloadCnt) cnt <= divReg;
    else if (strb.decCnt)    cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  // Transmit prescaler over base ticks
  always_ff @(posedge clk) begin
    if (rst)                  prescCnt <= '0;
    else if (strb.prescClear) prescCnt <= '0;
    else if (strb.prescStep)  prescCnt <= prescCnt + 1'b1;
  end

  // Master serial clock toggle
  always_ff @(posedge clk) begin
    if (rst)                  toggleQ <= 1'b0;
    else if (strb.toggleStep) toggleQ <= ~toggleQ;
  end

  // External clock synchronizer chain plus one history stage
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   histQ;

  always_ff @(posedge clk) begin
    if (rst) syncQ[0] <= 1'b0;
    else     syncQ[0] <= extClk;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) syncQ[s] <= 1'b0;
        else     syncQ[s] <= syncQ[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) histQ <= 1'b0;
    else     histQ <= syncQ[SYNC_STAGES-1];
  end

  assign extRise =  syncQ[SYNC_STAGES-1] & ~histQ;
  assign extFall = ~syncQ[SYNC_STAGES-1] &  histQ;

endmodule

// File: rtl/bcg_control.sv
module bcg_control
  import bcg_pkg::*;
#(
  parameter int PRESC_W   = 4,
  parameter int NORM_RATIO = 16,
  parameter int DBL_RATIO  = 8
) (
  input  logic               syncMode,
  input  logic               dblSpeed,
  input  logic               clkPinOut,
  input  logic               clkPolarity,
  input  logic               divHiWe,
  input  logic               divLoWe,
  input  logic               cntZero,
  input  logic               armed,
  input  logic [PRESC_W-1:0] prescCnt,
  input  logic               toggleQ,
  input  logic               extRise,
  input  logic               extFall,
  output bcg_strobes_t       strb,
  output logic               txTick,
  output logic               rxBaseTick,
  output logic               clkOut
);

  localparam logic [PRESC_W-1:0] NORM_TERM = PRESC_W'(NORM_RATIO - 1);
  localparam logic [PRESC_W-1:0] DBL_TERM  = PRESC_W'(DBL_RATIO - 1);

  bcg_mode_e        mode;
  logic             baseTick;
  logic             prescEnd;
  logic [PRESC_W-1:0] term;
  logic             launchEdge;
  logic             sampleEdge;

  // Double-speed only matters outside synchronous mode
  always_comb begin
    if (syncMode) mode = clkPinOut ? MODE_SYNC_MASTER : MODE_SYNC_SLAVE;
    else          mode = dblSpeed  ? MODE_ASYNC_DBL   : MODE_ASYNC_NORM;
  end

  assign baseTick = armed & cntZero;
  assign term     = (mode == MODE_ASYNC_DBL) ? DBL_TERM : NORM_TERM;
  assign prescEnd = (prescCnt >= term);

  assign launchEdge = clkPolarity ? extFall : extRise;
  assign sampleEdge = clkPolarity ? extRise : extFall;

  always_comb begin
    strb            = '0;
    strb.loadHi     = divHiWe;
    strb.loadLo     = divLoWe;
    strb.reloadCnt  = baseTick;
    strb.decCnt     = armed & ~cntZero;
    strb.prescStep  = baseTick & ~syncMode;
    strb.prescClear = baseTick & ~syncMode & prescEnd;
    strb.toggleStep = baseTick & (mode == MODE_SYNC_MASTER);
  end

  always_comb begin
    txTick     = 1'b0;
    rxBaseTick = 1'b0;
    clkOut     = 1'b0;
    unique case (mode)
      MODE_ASYNC_NORM, MODE_ASYNC_DBL: begin
        rxBaseTick = baseTick;
        txTick     = baseTick & prescEnd;
      end
      MODE_SYNC_MASTER: begin
        rxBaseTick = baseTick;
        txTick     = baseTick & (toggleQ == clkPolarity);
        clkOut     = toggleQ;
      end
      MODE_SYNC_SLAVE: begin
        rxBaseTick = sampleEdge;
        txTick     = launchEdge;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/baud_clock_gen.sv
module baud_clock_gen
  import bcg_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int BYTE_W      = 8,
  parameter int NORM_RATIO  = 16,
  parameter int DBL_RATIO   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              divHiWe,
  input  logic              divLoWe,
  input  logic [BYTE_W-1:0] divData,
  input  logic              syncMode,
  input  logic              dblSpeed,
  input  logic              clkPinOut,
  input  logic              clkPolarity,
  input  logic              extClk,
  output logic              txTick,
  output logic              rxBaseTick,
  output logic              clkOut
);

  localparam int PRESC_W = $clog2(NORM_RATIO);

  bcg_strobes_t       strb;
  logic               cntZero;
  logic               armed;
  logic [PRESC_W-1:0] prescCnt;
  logic               toggleQ;
  logic               extRise;
  logic               extFall;

  bcg_control #(
    .PRESC_W   (PRESC_W),
    .NORM_RATIO(NORM_RATIO),
    .DBL_RATIO (DBL_RATIO)
  ) u_ctrl (
    .syncMode   (syncMode),
    .dblSpeed   (dblSpeed),
    .clkPinOut  (clkPinOut),
    .clkPolarity(clkPolarity),
    .divHiWe    (divHiWe),
    .divLoWe    (divLoWe),
    .cntZero    (cntZero),
    .armed      (armed),
    .prescCnt   (prescCnt),
    .toggleQ    (toggleQ),
    .extRise    (extRise),
    .extFall    (extFall),
    .strb       (strb),
    .txTick     (txTick),
    .rxBaseTick (rxBaseTick),
    .clkOut     (clkOut)
  );

  bcg_datapath #(
    .DIV_W      (DIV_W),
    .BYTE_W     (BYTE_W),
    .PRESC_W    (PRESC_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .wrData  (divData),
    .extClk  (extClk),
    .cntZero (cntZero),
    .armed   (armed),
    .prescCnt(prescCnt),
    .toggleQ (toggleQ),
    .extRise (extRise),
    .extFall (extFall)
  );

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker (
  input logic clk,
  input logic rst,
  input logic divLoWe,
  input logic syncMode,
  input logic clkPinOut,
  input logic txTick,
  input logic rxBaseTick,
  input logic clkOut
);

  logic seenLo;
  logic master;
  logic slave;

  assign master = syncMode &  clkPinOut;
  assign slave  = syncMode & ~clkPinOut;

  always_ff @(posedge clk) begin
    if (rst)          seenLo <= 1'b0;
    else if (divLoWe) seenLo <= 1'b1;
  end

  // R9: no internal tick before the first lower-byte write
  assert_no_tick_unarmed_R9: assert property (@(posedge clk) disable iff (rst)
    (!seenLo && !slave) |-> !rxBaseTick);

  // R4: asynchronous transmit tick lands on a base tick
  assert_tx_on_base_R4: assert property (@(posedge clk) disable iff (rst)
    (txTick && !syncMode) |-> rxBaseTick);

  // R8: slave launch and sample pulses never coincide
  assert_slave_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    slave |-> !(txTick && rxBaseTick));

  // R8: slave pulses last one cycle
  assert_slave_pulse_width_R8: assert property (@(posedge clk) disable iff (rst)
    (slave && rxBaseTick) |=> (!slave || !rxBaseTick));

  // R6: master clock only moves after a base tick
  assert_clkout_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (master && $past(master) && !$past(rxBaseTick)) |-> $stable(clkOut));

  // R8: serial clock output low outside master mode
  assert_clkout_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !master |-> !clkOut);

endmodule

bind baud_clock_gen bcg_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .divLoWe   (divLoWe),
  .syncMode  (syncMode),
  .clkPinOut (clkPinOut),
  .txTick    (txTick),
  .rxBaseTick(rxBaseTick),
  .clkOut    (clkOut)
);

// File: tb/tb_baud_clock_gen.sv
module tb_baud_clock_gen;

  logic       clk = 1'b0;
  logic       rst;
  logic       divHiWe, divLoWe;
  logic [7:0] divData;
  logic       syncMode, dblSpeed, clkPinOut, clkPolarity, extClk;
  logic       txTick, rxBaseTick, clkOut;

  int  errors = 0;
  int  checks = 0;
  bit  done   = 1'b0;

  always #4 clk = ~clk;

  baud_clock_gen dut (
    .clk(clk), .rst(rst), .divHiWe(divHiWe), .divLoWe(divLoWe), .divData(divData),
    .syncMode(syncMode), .dblSpeed(dblSpeed), .clkPinOut(clkPinOut),
    .clkPolarity(clkPolarity), .extClk(extClk),
    .txTick(txTick), .rxBaseTick(rxBaseTick), .clkOut(clkOut)
  );

  // {sync, dbl, master, divisor, base period, tx period}
  localparam int NVEC = 6;
  localparam logic [46:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 12'd3, 16'd4,  16'd64},  // R1 R4
    {1'b0, 1'b1, 1'b0, 12'd3, 16'd4,  16'd32},  // R5
    {1'b0, 1'b0, 1'b0, 12'd0, 16'd1,  16'd16},  // R1 R4 divisor zero
    {1'b1, 1'b0, 1'b1, 12'd2, 16'd3,  16'd6},   // R6
    {1'b1, 1'b1, 1'b1, 12'd1, 16'd2,  16'd4},   // R6 double speed ignored
    {1'b0, 1'b1, 1'b0, 12'd9, 16'd10, 16'd80}   // R5
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; divHiWe = 0; divLoWe = 0; divData = 0; extClk = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic writeHi(input logic [7:0] v);
    @(negedge clk); divHiWe = 1'b1; divData = v;
    @(negedge clk); divHiWe = 1'b0;
  endtask

  task automatic writeLo(input logic [7:0] v);
    @(negedge clk); divLoWe = 1'b1; divData = v;
    @(negedge clk); divLoWe = 1'b0;
  endtask

  // Cycles from a lower-byte write edge to the first base tick
  task automatic loLatency(input logic [7:0] v, output int lat);
    lat = -1;
    @(negedge clk); divLoWe = 1'b1; divData = v;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (k == 0) divLoWe = 1'b0;
      if (rxBaseTick) begin lat = k; break; end
    end
  endtask

  task automatic measure(input bit useTx, output int per);
    per = -1;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (useTx ? txTick : rxBaseTick) break;
    end
    for (int j = 1; j < 20000; j++) begin
      @(negedge clk);
      if (useTx ? txTick : rxBaseTick) begin per = j; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int per, lat, cntTx, cntRx, cntClk, txAt, rxAt;
    rst = 1'b1; divHiWe = 0; divLoWe = 0; divData = 0;
    syncMode = 0; dblSpeed = 0; clkPinOut = 0; clkPolarity = 0; extClk = 0;

    // R9: reset state, then upper-byte write alone keeps everything idle (R3)
    syncMode = 1; clkPinOut = 1;
    doReset();
    writeHi(8'h00);
    cntTx = 0; cntRx = 0; cntClk = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      cntTx += txTick; cntRx += rxBaseTick; cntClk += clkOut;
    end
    check(cntRx == 0, "R9 rxBaseTick idle", cntRx, 0);
    check(cntTx == 0, "R9 txTick idle", cntTx, 0);
    check(cntClk == 0, "R3 clkOut idle after upper write only", cntClk, 0);

    // Vector table: R1 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      syncMode = VEC[i][46]; dblSpeed = VEC[i][45]; clkPinOut = VEC[i][44];
      clkPolarity = 0;
      doReset();
      writeHi({4'h0, VEC[i][43:40]});
      writeLo(VEC[i][39:32]);
      measure(1'b0, per);
      check(per == int'(VEC[i][31:16]), "R1 base period", per, int'(VEC[i][31:16]));
      measure(1'b1, per);
      check(per == int'(VEC[i][15:0]), "R4/R5/R6 tx period", per, int'(VEC[i][15:0]));
    end

    // R2: first tick latency, and immediate reload mid-count
    syncMode = 0; dblSpeed = 0; clkPinOut = 0;
    doReset();
    loLatency(8'd5, lat);
    check(lat == 5, "R2 first tick latency", lat, 5);
    loLatency(8'd100, lat);
    repeat (20) @(negedge clk);
    loLatency(8'd3, lat);
    check(lat == 3, "R2 reload mid-count", lat, 3);
    loLatency(8'd0, lat);
    check(lat == 0, "R2 zero divisor latency", lat, 0);

    // R3: upper byte contributes bits 11:8
    doReset();
    writeHi(8'h01);
    writeLo(8'h02);
    measure(1'b0, per);
    check(per == 259, "R3 divisor 0x102", per, 259);

    // R1: full-scale divisor
    doReset();
    writeHi(8'h0F);
    writeLo(8'hFF);
    measure(1'b0, per);
    check(per == 4096, "R1 divisor 4095", per, 4096);

    // R7: clkOut phase at txTick, both polarities
    for (int p = 0; p < 2; p++) begin
      syncMode = 1; clkPinOut = 1; dblSpeed = 0; clkPolarity = p[0];
      doReset();
      writeLo(8'd2);
      for (int k = 0; k < 100; k++) begin
        @(negedge clk);
        if (txTick) break;
      end
      check(clkOut == p[0], "R7 clkOut at txTick", clkOut, p);
      @(negedge clk);
      check(clkOut == !p[0], "R6 clkOut toggles after tick", clkOut, !p[0]);
    end

    // R8: slave mode, both polarities, both edges; counter armed at D=0
    for (int p = 0; p < 2; p++) begin
      syncMode = 1; clkPinOut = 0; clkPolarity = p[0];
      doReset();
      writeLo(8'd0);
      for (int e = 0; e < 2; e++) begin
        @(negedge clk); extClk = (e == 0);
        txAt = -1; rxAt = -1; cntTx = 0; cntRx = 0; cntClk = 0;
        for (int k = 0; k < 6; k++) begin
          @(negedge clk);
          if (txTick) begin cntTx++; txAt = k; end
          if (rxBaseTick) begin cntRx++; rxAt = k; end
          cntClk += clkOut;
        end
        // launch edge: rising for polarity 0, falling for polarity 1
        if ((e == 0) == (p == 0)) begin
          check(cntTx == 1 && txAt == 1, "R8 launch pulse on txTick", txAt, 1);
          check(cntRx == 0, "R8 no sample pulse", cntRx, 0);
        end else begin
          check(cntRx == 1 && rxAt == 1, "R8 sample pulse on rxBaseTick", rxAt, 1);
          check(cntTx == 0, "R8 no launch pulse", cntTx, 0);
        end
        check(cntClk == 0, "R8 clkOut low in slave", cntClk, 0);
      end
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule